// File: doc/BRIEF.md
# Dual-Clock Mailbox Interrupt Pair

This block gives two processors, each on its own side of a shared memory and each on its own clock, a way to signal each other. Each side owns one outgoing mailbox word in the top two locations of the address space. When a side writes its outgoing mailbox, the other side's interrupt goes low. When the receiving side reads that word, its interrupt goes high again and it gets the posted data. The rest of the memory and the arbitration between the two sides are outside this block.

The left side posts at the highest address (all ones, 3FFFF hex for 18 address bits). The right side posts at the next address down (3FFFE hex). A post is recorded in the writer's clock domain as a toggle. The toggle passes through a synchronizer chain into the reader's domain, and the interrupt flag lives in that domain. The clear is therefore local to the clock that reads it. All state resets asynchronously on the active-low master reset.

Top module: `mbx_irq_pair`

## Requirements
- R1: While and after master reset (`mrst_n` low), both interrupt outputs are high (inactive) and both read-data outputs are zero.
- R2: An enabled left write (`l_en`=1, `l_wr`=1) to address 3FFFF drives `r_int_n` low within SYNC_STAGES+1 right-clock edges.
- R3: An enabled right read (`r_en`=1, `r_wr`=0) at 3FFFF returns `r_int_n` high at that right-clock edge.
- R4: An enabled right write to address 3FFFE drives `l_int_n` low within SYNC_STAGES+1 left-clock edges.
- R5: An enabled left read at 3FFFE returns `l_int_n` high at that left-clock edge.
- R6: With the port enable low, a write or read at either mailbox address leaves both interrupts unchanged.
- R7: An access to any address other than 3FFFF or 3FFFE leaves both interrupts unchanged. This includes a side writing its incoming mailbox address (right writing 3FFFF, left writing 3FFFE).
- R8: One clock after an enabled read of its incoming mailbox, a port's read data equals the last word the other side posted. After any other cycle, that port's read data is zero.
- R9: The two interrupts are independent. A pending interrupt stays low across further posts and across the other side's traffic until its own clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mrst_n | input | 1 | Asynchronous master reset, active low, both domains |
| lclk | input | 1 | Left port clock |
| l_en | input | 1 | Left access enable, active high |
| l_wr | input | 1 | Left access type: 1 write, 0 read |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, registered |
| l_int_n | output | 1 | Left interrupt, active low |
| rclk | input | 1 | Right port clock |
| r_en | input | 1 | Right access enable, active high |
| r_wr | input | 1 | Right access type: 1 write, 0 read |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, registered |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The assertions assume that each port's inputs are stable around its own clock edge. They also assume the receiver does not read a mailbox word in the same few cycles that a new post for it is still crossing domains, because the data register is only guaranteed settled once the flag has risen. The stimulus changes each port's inputs on the falling edge of that port's clock. It waits several reader clocks after every post before checking or reading. The two clocks have unrelated periods, so the crossing is exercised at varying phases.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Kind of access a port presents in a cycle
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;

  // Fewest flops allowed in a clock-crossing chain
  localparam int MIN_SYNC = 2;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter logic [ADDR_W-1:0] OUT_LOC = '1,
  parameter logic [ADDR_W-1:0] IN_LOC  = '0
) (
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              post,
  output logic              take
);
  acc_e kind;

  always_comb begin
    if (!en)      kind = ACC_IDLE;
    else if (wr)  kind = ACC_WR;
    else          kind = ACC_RD;
  end

  // Writing own outbound word posts; reading inbound word takes
  assign post = (kind == ACC_WR) && (addr == OUT_LOC);
  assign take = (kind == ACC_RD) && (addr == IN_LOC);
endmodule

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              rst_n,
  input  logic              wclk,
  input  logic              post,
  input  logic [DATA_W-1:0] post_data,
  output logic [DATA_W-1:0] box_q,
  input  logic              rclk,
  input  logic              take,
  output logic              pending
);
  logic post_tgl;
  logic tgl_s;
  logic seen;
  logic arrive;

  // Writer domain: store the word and flip the event toggle
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      post_tgl <= 1'b0;
      box_q    <= '0;
    end else if (post) begin
      post_tgl <= ~post_tgl;
      box_q    <= post_data;
    end
  end

  mbx_sync #(.STAGES(STAGES)) u_sync (
    .clk  (rclk),
    .rst_n(rst_n),
    .d    (post_tgl),
    .q    (tgl_s)
  );

  assign arrive = tgl_s ^ seen;

  // Reader domain: a new arrival wins over a same-cycle take
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      pending <= 1'b0;
    end else begin
      seen <= tgl_s;
      if (arrive)    pending <= 1'b1;
      else if (take) pending <= 1'b0;
    end
  end

  // R2
  post_tgl_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (post_tgl != $past(post_tgl)) |-> $past(post));

  // R3
  take_clr_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (take && !arrive) |=> !pending);

  // R9
  hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (pending && !take) |=> pending);
endmodule

// File: rtl/mbx_rdport.sv
module mbx_rdport #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] box,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata <= '0;
    else if (take) rdata <= box;
    else           rdata <= '0;
  end

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (rdata == '0));
endmodule

// File: rtl/mbx_irq_pair.sv
module mbx_irq_pair
  import mbx_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              mrst_n,
  input  logic              lclk,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_int_n,
  input  logic              rclk,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_int_n
);
  localparam int STAGES = (SYNC_STAGES < MIN_SYNC) ? MIN_SYNC : SYNC_STAGES;
  localparam logic [ADDR_W-1:0] TOP_LOC  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXT_LOC = {{(ADDR_W-1){1'b1}}, 1'b0};

  // Index 0 = left, 1 = right
  logic [1:0]              clk_v;
  logic [1:0]              en_v, wr_v, post_v, take_v, pend_v;
  logic [ADDR_W-1:0]       addr_v  [2];
  logic [DATA_W-1:0]       wdata_v [2];
  logic [DATA_W-1:0]       rdata_v [2];
  logic [DATA_W-1:0]       box_v   [2];

  assign clk_v      = {rclk, lclk};
  assign en_v       = {r_en, l_en};
  assign wr_v       = {r_wr, l_wr};
  assign addr_v[0]  = l_addr;
  assign addr_v[1]  = r_addr;
  assign wdata_v[0] = l_wdata;
  assign wdata_v[1] = r_wdata;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_side
      // Side g posts at its own word; takes from the other side's word
      localparam logic [ADDR_W-1:0] OWN  = (g == 0) ? TOP_LOC : NEXT_LOC;
      localparam logic [ADDR_W-1:0] PEER = (g == 0) ? NEXT_LOC : TOP_LOC;

      mbx_decode #(
        .ADDR_W (ADDR_W),
        .OUT_LOC(OWN),
        .IN_LOC (PEER)
      ) u_dec (
        .en  (en_v[g]),
        .wr  (wr_v[g]),
        .addr(addr_v[g]),
        .post(post_v[g]),
        .take(take_v[g])
      );

      // Channel g carries posts from side g to side 1-g
      mbx_channel #(
        .DATA_W(DATA_W),
        .STAGES(STAGES)
      ) u_chan (
        .rst_n    (mrst_n),
        .wclk     (clk_v[g]),
        .post     (post_v[g]),
        .post_data(wdata_v[g]),
        .box_q    (box_v[g]),
        .rclk     (clk_v[1-g]),
        .take     (take_v[1-g]),
        .pending  (pend_v[g])
      );

      mbx_rdport #(.DATA_W(DATA_W)) u_rd (
        .clk  (clk_v[g]),
        .rst_n(mrst_n),
        .take (take_v[g]),
        .box  (box_v[1-g]),
        .rdata(rdata_v[g])
      );
    end
  endgenerate

  assign l_rdata = rdata_v[0];
  assign r_rdata = rdata_v[1];
  assign l_int_n = ~pend_v[1];
  assign r_int_n = ~pend_v[0];

  // R6
  l_idle_chk: assert property (@(posedge lclk) disable iff (!mrst_n)
    !l_en |-> !(post_v[0] || take_v[0]));

  // R6
  r_idle_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
    !r_en |-> !(post_v[1] || take_v[1]));

  // R7
  l_addr_chk: assert property (@(posedge lclk) disable iff (!mrst_n)
    (l_addr != TOP_LOC && l_addr != NEXT_LOC) |-> !(post_v[0] || take_v[0]));

  // R7
  r_addr_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
    (r_addr != TOP_LOC && r_addr != NEXT_LOC) |-> !(post_v[1] || take_v[1]));
endmodule

// File: tb/mbx_irq_pair_test.sv
module mbx_irq_pair_test;
  localparam int AW = 18;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_HI = 18'h3FFFF;
  localparam logic [AW-1:0] A_LO = 18'h3FFFE;

  logic mrst_n = 1'b0;
  logic lclk = 1'b0, rclk = 1'b0;
  logic l_en = 0, l_wr = 0, r_en = 0, r_wr = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_int_n, r_int_n;

  int checks = 0;
  int fails  = 0;

  always #10 lclk = ~lclk;   // 50 MHz
  always #17 rclk = ~rclk;

  mbx_irq_pair #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) uut (
    .mrst_n(mrst_n),
    .lclk(lclk), .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_int_n(l_int_n),
    .rclk(rclk), .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_int_n(r_int_n)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access at a left edge; returns at the following falling edge
  task automatic lacc(input logic en, input logic wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    @(negedge lclk);
    l_en = en; l_wr = wr; l_addr = a; l_wdata = d;
    @(negedge lclk);
    l_en = 0; l_wr = 0; l_addr = '0; l_wdata = '0;
  endtask

  task automatic racc(input logic en, input logic wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    @(negedge rclk);
    r_en = en; r_wr = wr; r_addr = a; r_wdata = d;
    @(negedge rclk);
    r_en = 0; r_wr = 0; r_addr = '0; r_wdata = '0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge lclk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge lclk);
    chk(l_int_n === 1'b1, "R1 l_int_n in reset", {31'b0, l_int_n}, 1);
    chk(r_int_n === 1'b1, "R1 r_int_n in reset", {31'b0, r_int_n}, 1);
    chk(l_rdata === '0, "R1 l_rdata in reset", l_rdata, 0);
    chk(r_rdata === '0, "R1 r_rdata in reset", r_rdata, 0);
    mrst_n = 1'b1;
    settle();
    chk(l_int_n === 1'b1 && r_int_n === 1'b1, "R1 after release",
        {30'b0, l_int_n, r_int_n}, 3);
  endtask

  task automatic t_l2r();
    lacc(1, 1, A_HI, 32'hA5A5_0001);
    repeat (4) @(negedge rclk);
    chk(r_int_n === 1'b0, "R2 right interrupt raised", {31'b0, r_int_n}, 0);
    chk(l_int_n === 1'b1, "R9 left untouched", {31'b0, l_int_n}, 1);
    racc(1, 0, A_HI, '0);
    chk(r_int_n === 1'b1, "R3 right interrupt cleared", {31'b0, r_int_n}, 1);
    chk(r_rdata === 32'hA5A5_0001, "R8 right read data", r_rdata, 32'hA5A5_0001);
    @(negedge rclk);
    chk(r_rdata === '0, "R8 right data idle zero", r_rdata, 0);
  endtask

  task automatic t_r2l();
    racc(1, 1, A_LO, 32'h0BAD_CAFE);
    repeat (4) @(negedge lclk);
    chk(l_int_n === 1'b0, "R4 left interrupt raised", {31'b0, l_int_n}, 0);
    chk(r_int_n === 1'b1, "R9 right untouched", {31'b0, r_int_n}, 1);
    lacc(1, 0, A_LO, '0);
    chk(l_int_n === 1'b1, "R5 left interrupt cleared", {31'b0, l_int_n}, 1);
    chk(l_rdata === 32'h0BAD_CAFE, "R8 left read data", l_rdata, 32'h0BAD_CAFE);
  endtask

  task automatic t_disabled();
    lacc(0, 1, A_HI, 32'h1);
    racc(0, 1, A_LO, 32'h2);
    settle();
    chk(r_int_n === 1'b1 && l_int_n === 1'b1, "R6 disabled writes ignored",
        {30'b0, l_int_n, r_int_n}, 3);
    lacc(1, 1, A_HI, 32'h3);
    settle();
    racc(0, 0, A_HI, '0);
    chk(r_int_n === 1'b0, "R6 disabled read keeps interrupt", {31'b0, r_int_n}, 0);
    chk(r_rdata === '0, "R8 disabled read returns zero", r_rdata, 0);
    racc(1, 0, A_HI, '0);
    chk(r_int_n === 1'b1, "R3 clear after disabled read", {31'b0, r_int_n}, 1);
  endtask

  task automatic t_other_addr();
    lacc(1, 1, 18'h3FFFD, 32'h4);
    lacc(1, 1, A_LO, 32'h5);     // left writing its incoming word
    racc(1, 1, A_HI, 32'h6);     // right writing its incoming word
    racc(1, 1, 18'h00000, 32'h7);
    settle();
    chk(r_int_n === 1'b1 && l_int_n === 1'b1, "R7 other writes ignored",
        {30'b0, l_int_n, r_int_n}, 3);
    racc(1, 1, A_LO, 32'h8);
    settle();
    lacc(1, 0, 18'h1FFFF, '0);
    lacc(1, 0, A_HI, '0);        // left reading its own outbound word
    chk(l_int_n === 1'b0, "R7 other reads keep interrupt", {31'b0, l_int_n}, 0);
    chk(l_rdata === '0, "R8 non-inbound read returns zero", l_rdata, 0);
    lacc(1, 0, A_LO, '0);
    chk(l_rdata === 32'h8, "R8 inbound word unchanged by others", l_rdata, 32'h8);
  endtask

  task automatic t_independent();
    lacc(1, 1, A_HI, 32'h10);
    racc(1, 1, A_LO, 32'h20);
    settle();
    lacc(1, 1, A_HI, 32'h11);   // second post while pending
    settle();
    chk(l_int_n === 1'b0 && r_int_n === 1'b0, "R9 both pending",
        {30'b0, l_int_n, r_int_n}, 0);
    lacc(1, 0, A_LO, '0);
    chk(l_int_n === 1'b1, "R5 left clear alone", {31'b0, l_int_n}, 1);
    settle();
    chk(r_int_n === 1'b0, "R9 right still pending", {31'b0, r_int_n}, 0);
    racc(1, 0, A_HI, '0);
    chk(r_rdata === 32'h11, "R8 latest post read", r_rdata, 32'h11);
    chk(r_int_n === 1'b1, "R3 right clear", {31'b0, r_int_n}, 1);
  endtask

  task automatic t_midreset();
    lacc(1, 1, A_HI, 32'h99);
    settle();
    @(negedge lclk);
    mrst_n = 1'b0;
    #1;
    chk(r_int_n === 1'b1, "R1 async reset clears interrupt", {31'b0, r_int_n}, 1);
    @(negedge lclk);
    mrst_n = 1'b1;
    settle();
    chk(r_int_n === 1'b1, "R1 stays clear after reset", {31'b0, r_int_n}, 1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_l2r();
    t_r2l();
    t_disabled();
    t_other_addr();
    t_independent();
    t_midreset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule